// File: doc/BRIEF.md
# Transition-Cleared Watchdog Timer

This block guards a system against a stalled controller. Software or hardware is expected to toggle a single watchdog line at regular intervals. Every change of that line, whether it rises or falls, restarts an idle counter. If the counter runs through a full timeout window without seeing a change, the block raises a one-cycle expiry pulse. The reset controller turns that pulse into a system reset.

The timeout is a parameter counted in clock cycles. The default, 80,000,000 cycles, gives 1.6 s at a 50 MHz clock. Tests shorten it to a few dozen cycles. While the reset controller holds its reset-active input high, the counter is frozen at zero, the input synchronizer is cleared and the output stays low. When reset-active is released, the block re-arms.

The watchdog line is asynchronous to the clock, so it passes through a synchronizer before edges are detected. After the expiry pulse, the block stays idle and gives no further pulses until reset-active has been asserted and released again. The block has no data stream, so all of its pins are plain control signals with no valid/ready handshake.

Top module: `wdk_kick_timer`

## Requirements
- R1: While `sys_rst_i` is high, `expire_o` is low on every cycle, whatever `wd_line_i` does, and the counter is held at zero.
- R2: A rising transition of `wd_line_i` restarts the timeout window.
- R3: A falling transition of `wd_line_i` restarts the timeout window, exactly as a rising one does.
- R4: If no transition is detected for TIMEOUT_CYC consecutive clock edges, `expire_o` is high in the cycle after the TIMEOUT_CYC-th such edge.
- R5: With the default two synchronizer stages, a new `wd_line_i` value sampled at clock edge k clears the counter at edge k+2, so the next expiry follows edge k+2+TIMEOUT_CYC.
- R6: `expire_o` is high for exactly one cycle. After that it stays low until `sys_rst_i` has been asserted and then released.
- R7: A transition that is detected on the same edge at which the counter reaches its terminal count takes priority: no pulse is produced, and the window restarts.
- R8: After `sys_rst_i` is released, a full TIMEOUT_CYC window must elapse before any expiry, because the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_i | input | 1 | Reset-active input from the reset controller. It is synchronous and active high, and it freezes and clears the block. |
| wd_line_i | input | 1 | Watchdog line, asynchronous. Any change counts as activity. |
| expire_o | output | 1 | One-cycle pulse when the timeout window elapses with no activity. |

## Verification
The assertions assume that `sys_rst_i` is held high from time zero until the first clock edge. They also assume that the watchdog line, after its synchronizer, is the only source of kicks, so the checker measures quiet time from the detected-kick signal rather than from the raw pin.

The bench drives every input on the falling clock edge, so the line is never sampled at the moment it changes. Its random phases combine these elements:
- bursts of toggling,
- quiet stretches longer than the window,
- short assertions of reset-active.

Together they reach expiry, kicks near the terminal count, and re-arming.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  typedef enum logic {
    WDK_ARMED = 1'b0,
    WDK_SPENT = 1'b1
  } wdk_state_e;

  function automatic int wdk_cnt_width(input int unsigned limit);
    int w;
    w = 1;
    while ((64'd1 << w) < 64'(limit)) w++;
    return w;
  endfunction

endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (clr_i) chain[0] <= 1'b0;
        else       chain[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (clr_i) chain[g] <= 1'b0;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wdk_edge.sv
module wdk_edge (
  input  logic clk,
  input  logic clr_i,
  input  logic lvl_i,
  output logic kick_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (clr_i) lvl_q <= 1'b0;
    else       lvl_q <= lvl_i;
  end

  assign kick_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/wdk_count.sv
module wdk_count
  import wdk_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 80_000_000
) (
  input  logic clk,
  input  logic clr_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = wdk_cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  wdk_state_e      state;
  logic [CW-1:0]   idle_cnt;
  logic            at_last;

  assign at_last = (idle_cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr_i) begin
      state    <= WDK_ARMED;
      idle_cnt <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      case (state)
        WDK_ARMED: begin
          if (kick_i) begin
            idle_cnt <= '0;
          end else if (at_last) begin
            idle_cnt <= '0;
            expire_o <= 1'b1;
            state    <= WDK_SPENT;
          end else begin
            idle_cnt <= idle_cnt + CW'(1);
          end
        end
        default: begin
          idle_cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wdk_kick_timer.sv
module wdk_kick_timer #(
  parameter int unsigned TIMEOUT_CYC = 80_000_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic sys_rst_i,
  input  logic wd_line_i,
  output logic expire_o
);
  logic line_sync;
  logic line_kick;

  wdk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .clr_i (sys_rst_i),
    .d_i   (wd_line_i),
    .q_o   (line_sync)
  );

  wdk_edge u_edge (
    .clk    (clk),
    .clr_i  (sys_rst_i),
    .lvl_i  (line_sync),
    .kick_o (line_kick)
  );

  wdk_count #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_count (
    .clk      (clk),
    .clr_i    (sys_rst_i),
    .kick_i   (line_kick),
    .expire_o (expire_o)
  );
endmodule

// File: rtl/wdk_kick_timer_chk.sv
module wdk_kick_timer_chk #(
  parameter int unsigned TIMEOUT_CYC = 80_000_000
) (
  input logic clk,
  input logic sys_rst_i,
  input logic kick,
  input logic expire_o
);
  localparam int QW = wdk_pkg::wdk_cnt_width(TIMEOUT_CYC + 2);
  localparam logic [QW-1:0] QMAX = QW'(TIMEOUT_CYC + 1);
  localparam logic [QW-1:0] QEXP = QW'(TIMEOUT_CYC);

  logic [QW-1:0] quiet;
  logic          fired;

  always_ff @(posedge clk) begin
    if (sys_rst_i) begin
      quiet <= '0;
      fired <= 1'b0;
    end else begin
      if (kick)               quiet <= '0;
      else if (quiet != QMAX) quiet <= quiet + QW'(1);
      if (expire_o)           fired <= 1'b1;
    end
  end

  // R1: output low in the cycle after reset-active was sampled high
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    sys_rst_i |=> !expire_o);

  // R4: a pulse only after a full quiet window
  assert_full_window_R4: assert property (@(posedge clk) disable iff (sys_rst_i)
    expire_o |-> (quiet == QEXP));

  // R6: pulse lasts one cycle
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (sys_rst_i)
    expire_o |=> !expire_o);

  // R6: no second pulse before re-arm
  assert_no_repeat_R6: assert property (@(posedge clk) disable iff (sys_rst_i)
    fired |-> !expire_o);

  // R7: a detected kick never yields a pulse on that edge
  assert_kick_wins_R7: assert property (@(posedge clk) disable iff (sys_rst_i)
    kick |=> !expire_o);
endmodule

bind wdk_kick_timer wdk_kick_timer_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .sys_rst_i (sys_rst_i),
  .kick      (line_kick),
  .expire_o  (expire_o)
);

// File: tb/wdk_kick_timer_bench.sv
`timescale 1ns/1ps
module wdk_kick_timer_bench;
  localparam int unsigned T = 40;

  logic clk = 1'b0;
  logic sys_rst_i = 1'b1;
  logic wd_line_i = 1'b0;
  logic expire_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdk_kick_timer #(.TIMEOUT_CYC(T)) u_wdk_kick_timer (
    .clk       (clk),
    .sys_rst_i (sys_rst_i),
    .wd_line_i (wd_line_i),
    .expire_o  (expire_o)
  );

  // Expected-value model from R1..R8: two-edge sync latency, clear on any
  // change, pulse after T quiet edges, kick wins at terminal, idle until re-arm.
  logic m_s1, m_s2, m_prev, m_armed, m_exp;
  int   m_cnt;

  always @(posedge clk) begin
    if (sys_rst_i) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
      m_armed <= 1; m_exp <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= wd_line_i; m_s2 <= m_s1; m_prev <= m_s2;
      m_exp <= 0;
      if (!m_armed) m_cnt <= 0;
      else if (m_s2 != m_prev) m_cnt <= 0;
      else if (m_cnt == int'(T) - 1) begin
        m_exp <= 1; m_armed <= 0; m_cnt <= 0;
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic cmp(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s expire_o act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(string req);
    @(negedge clk);
    cmp(req, expire_o, m_exp);
  endtask

  task automatic rearm(logic lvl);
    sys_rst_i = 1'b1;
    wd_line_i = lvl;
    repeat (3) cyc("R1");
    sys_rst_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240917));

    // R1: reset-active with a toggling line
    for (int i = 0; i < 12; i++) begin
      cyc("R1");
      cmp("R1", expire_o, 1'b0);
      wd_line_i = ~wd_line_i;
    end
    wd_line_i = 1'b0;
    repeat (3) cyc("R1");
    sys_rst_i = 1'b0;

    // R8, R4: full window from release, exact pulse edge
    for (int i = 1; i <= int'(T); i++) begin
      cyc("R8");
      if (i == int'(T) - 1) cmp("R8", expire_o, 1'b0);
      if (i == int'(T))     cmp("R4", expire_o, 1'b1);
    end
    // R6: one cycle wide, no repeat while not re-armed
    for (int i = 0; i < 3 * int'(T); i++) begin
      cyc("R6");
      cmp("R6", expire_o, 1'b0);
    end

    // R2, R5: rising edge sampled at edge 20
    rearm(1'b0);
    for (int i = 1; i <= 70; i++) begin
      cyc("R2");
      if (i == int'(T))     cmp("R2", expire_o, 1'b0);
      if (i == int'(T) + 21) cmp("R5", expire_o, 1'b0);
      if (i == int'(T) + 22) cmp("R5", expire_o, 1'b1);
      if (i == 19) wd_line_i = 1'b1;
    end

    // R3: falling edge; release with line high kicks at edge 3
    rearm(1'b1);
    for (int i = 1; i <= 60; i++) begin
      cyc("R3");
      if (i == int'(T) + 3)  cmp("R3", expire_o, 1'b0);
      if (i == int'(T) + 13) cmp("R3", expire_o, 1'b1);
      if (i == 10) wd_line_i = 1'b0;
    end

    // R7: kick detected on the terminal-count edge
    rearm(1'b0);
    for (int i = 1; i <= 2 * int'(T) + 2; i++) begin
      cyc("R7");
      if (i == int'(T))     cmp("R7", expire_o, 1'b0);
      if (i == 2 * int'(T)) cmp("R7", expire_o, 1'b1);
      if (i == int'(T) - 3) wd_line_i = 1'b1;
    end

    // Random mix of busy, quiet and reset segments
    for (int s = 0; s < 200; s++) begin
      int len  = 20 + int'($urandom_range(130));
      int mode = int'($urandom_range(9));
      if (mode == 0) begin
        sys_rst_i = 1'b1;
        repeat (2 + $urandom_range(3)) cyc("R1");
        sys_rst_i = 1'b0;
      end
      for (int i = 0; i < len; i++) begin
        cyc("R4");
        if (mode >= 5 && $urandom_range(7) == 0) wd_line_i = ~wd_line_i;
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule